// File: doc/BRIEF.md
# Keyed Watchdog Timer

A memory-mapped watchdog for a 32-bit register bus. Software programs a timeout by loading a 16-bit up-counter with 65536 minus the wanted number of prescaled ticks. It then enables counting through a control register. When the counter rolls over from 0xFFFF to 0 while counting is enabled, the block latches an overflow flag and drives a reset request for a fixed number of clock cycles.

Every register write is guarded. The upper part of the write data must hold a fixed pattern, and that pattern differs between the counter register and the two control registers. A write that fails the pattern check changes nothing. A new count does not reach the counter at once. It passes through a short synchronisation stage, and while it does a busy flag is set. Software polls that flag before it sets the enable bit.

There are two reset inputs. The power-on reset clears everything. The system reset, which is normally driven by the block's own reset request, clears everything except the overflow flag. Software can therefore read the flag after a restart and tell that the restart came from the watchdog.

Top module: `keyguard_wdt`

## Requirements
- R1: After reset the counter (offset 0), the control word (offset 4), the auxiliary byte (offset 8) and the reset request all read 0.
- R2: A write to offset 0 is taken only when data[31:16] is 0x5A5A, and the new count is data[15:0]. Any other upper pattern, including the control key, leaves the counter unchanged.
- R3: A write to offset 4 or offset 8 is taken only when data[31:8] is 0xA5A5A5, and the value is data[7:0]. Control word layout: [2:0] divider select, [4] overflow flag, [5] busy flag (read only), [7] enable. Bits 3 and 6 read 0.
- R4: After an accepted counter write the busy flag reads 1 for exactly 2 clock cycles. The counter takes the new value on the edge where the busy flag falls.
- R5: While enabled, the counter advances once every D clock cycles, where divider select 0..7 gives D = 1, 4, 16, 32, 64, 128, 1024, 4096. The first increment comes D cycles after the enabling write.
- R6: While disabled, the counter holds its value and the prescaler is cleared. Clearing the enable bit stops the count without changing it.
- R7: A rollover from 0xFFFF to 0 while enabled sets the overflow flag and drives the reset request high for 16 consecutive clock cycles.
- R8: Writing 0 to bit 4 of the control word clears the overflow flag, and writing 1 to it has no effect. If a rollover falls in the same cycle as a clearing write, the flag ends up set.
- R9: The system reset clears all state except the overflow flag. Only the power-on reset clears that flag.
- R10: Read data is registered. It reflects the address presented one cycle earlier, and addresses other than 0, 4 and 8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high; clears all state |
| rst_sys | input | 1 | System reset, synchronous, active high; keeps the overflow flag |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data, including the key |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Registered read data |
| wdt_rst_req | output | 1 | Reset request pulse |

## Verification
Two functions can meet in one cycle: the rollover that sets the overflow flag, and a software write that clears the same flag. The bench loads 0xFFFF with the divider at 1, enables the timer, and then issues a clearing write to the control word on the very next edge, which is the rollover edge. It then reads back the control word and expects the flag to be set. A second clearing write, issued afterwards, must clear it.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam logic [15:0] CNT_KEY = 16'h5A5A;
  localparam logic [23:0] CTL_KEY = 24'hA5A5A5;

  localparam int unsigned OFS_CNT = 0;
  localparam int unsigned OFS_CTL = 4;
  localparam int unsigned OFS_AUX = 8;

  localparam int unsigned BIT_OVF  = 4;
  localparam int unsigned BIT_BUSY = 5;
  localparam int unsigned BIT_EN   = 7;

  // log2 of the prescaler divisor for each select value
  function automatic int unsigned div_shift(input logic [2:0] sel);
    case (sel)
      3'd0:    return 0;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 10;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/kwdt_regif.sv
module kwdt_regif
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              rst_any,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              we,
  output logic              cnt_wr,
  output logic              ctl_wr,
  output logic              aux_wr,
  output logic [CNT_W-1:0]  cnt_val,
  output logic [BYTE_W-1:0] byte_val
);
  logic go;
  logic cnt_key_ok;
  logic ctl_key_ok;

  always_comb begin
    go         = we && !rst_any;
    cnt_key_ok = (wdata[BUS_W-1:CNT_W] == CNT_KEY);
    ctl_key_ok = (wdata[BUS_W-1:BYTE_W] == CTL_KEY);
    cnt_wr     = go && cnt_key_ok && (addr == ADDR_W'(OFS_CNT));
    ctl_wr     = go && ctl_key_ok && (addr == ADDR_W'(OFS_CTL));
    aux_wr     = go && ctl_key_ok && (addr == ADDR_W'(OFS_AUX));
    cnt_val    = wdata[CNT_W-1:0];
    byte_val   = wdata[BYTE_W-1:0];
  end
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
  import kwdt_pkg::*;
#(
  parameter int unsigned PRE_W = 12
) (
  input  logic       clk,
  input  logic       rst_any,
  input  logic       en,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] mask;

  always_comb begin
    span = (PRE_W+1)'(1) << div_shift(sel);
    mask = PRE_W'(span - (PRE_W+1)'(1));
    tick = en && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst_any || !en) pre_q <= '0;
    else                pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_any,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic             wrap
);
  localparam int unsigned STG_W = (SYNC_STAGES > 1) ? $clog2(SYNC_STAGES) : 1;
  localparam logic [STG_W-1:0] STG_LAST = STG_W'(SYNC_STAGES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ld_q;
  logic [STG_W-1:0] stg_q;
  logic             busy_q;
  logic             load_now;

  always_comb begin
    load_now = busy_q && (stg_q == STG_LAST) && !wr_en;
    wrap     = tick && (cnt_q == '1) && !load_now;
    cnt      = cnt_q;
    busy     = busy_q;
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      busy_q <= 1'b0;
      stg_q  <= '0;
      ld_q   <= '0;
    end else if (wr_en) begin
      busy_q <= 1'b1;
      stg_q  <= '0;
      ld_q   <= wr_val;
    end else if (busy_q) begin
      if (stg_q == STG_LAST) begin
        busy_q <= 1'b0;
        stg_q  <= '0;
      end else begin
        stg_q <= stg_q + STG_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_any)       cnt_q <= '0;
    else if (load_now) cnt_q <= ld_q;
    else if (tick)     cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_por,
  input  logic fire,
  output logic req
);
  localparam int unsigned LW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  logic [LW-1:0] left_q;
  logic          req_q;

  always_ff @(posedge clk) begin
    if (rst_por) begin
      left_q <= '0;
      req_q  <= 1'b0;
    end else if (fire) begin
      left_q <= LW'(PULSE_LEN - 1);
      req_q  <= 1'b1;
    end else if (left_q != '0) begin
      left_q <= left_q - LW'(1);
    end else begin
      req_q <= 1'b0;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned PRE_W       = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PULSE_LEN   = 16
) (
  input  logic              clk,
  input  logic              rst_por,
  input  logic              rst_sys,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_req
);
  logic              rst_any;
  logic              cnt_wr, ctl_wr, aux_wr;
  logic [CNT_W-1:0]  cnt_val;
  logic [BYTE_W-1:0] byte_val;
  logic [2:0]        sel_q;
  logic              en_q;
  logic              ovf_q;
  logic [BYTE_W-1:0] aux_q;
  logic              tick_w;
  logic [CNT_W-1:0]  cnt_q;
  logic              pend_w;
  logic              wrap_w;
  logic [BYTE_W-1:0] ctl_view;
  logic [31:0]       rd_next;
  logic [31:0]       rdata_q;

  assign rst_any = rst_por || rst_sys;

  kwdt_regif #(.ADDR_W(ADDR_W)) u_regif (
    .rst_any (rst_any),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .we      (bus_we),
    .cnt_wr  (cnt_wr),
    .ctl_wr  (ctl_wr),
    .aux_wr  (aux_wr),
    .cnt_val (cnt_val),
    .byte_val(byte_val)
  );

  kwdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_any(rst_any),
    .en     (en_q),
    .sel    (sel_q),
    .tick   (tick_w)
  );

  kwdt_counter #(.SYNC_STAGES(SYNC_STAGES)) u_cnt (
    .clk    (clk),
    .rst_any(rst_any),
    .tick   (tick_w),
    .wr_en  (cnt_wr),
    .wr_val (cnt_val),
    .cnt    (cnt_q),
    .busy   (pend_w),
    .wrap   (wrap_w)
  );

  kwdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk    (clk),
    .rst_por(rst_por),
    .fire   (wrap_w),
    .req    (wdt_rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst_any) begin
      sel_q <= '0;
      en_q  <= 1'b0;
      aux_q <= '0;
    end else begin
      if (ctl_wr) begin
        sel_q <= byte_val[2:0];
        en_q  <= byte_val[BIT_EN];
      end
      if (aux_wr) aux_q <= byte_val;
    end
  end

  // overflow flag lives in the power-on domain only
  always_ff @(posedge clk) begin
    if (rst_por)                         ovf_q <= 1'b0;
    else if (wrap_w)                     ovf_q <= 1'b1;
    else if (ctl_wr && !byte_val[BIT_OVF]) ovf_q <= 1'b0;
  end

  always_comb begin
    ctl_view           = '0;
    ctl_view[2:0]      = sel_q;
    ctl_view[BIT_OVF]  = ovf_q;
    ctl_view[BIT_BUSY] = pend_w;
    ctl_view[BIT_EN]   = en_q;
    if (bus_addr == ADDR_W'(OFS_CNT))      rd_next = {16'h0, cnt_q};
    else if (bus_addr == ADDR_W'(OFS_CTL)) rd_next = {24'h0, ctl_view};
    else if (bus_addr == ADDR_W'(OFS_AUX)) rd_next = {24'h0, aux_q};
    else                                   rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst_any) rdata_q <= '0;
    else         rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker (
  input logic        clk,
  input logic        rst_por,
  input logic        rst_sys,
  input logic [15:0] cnt,
  input logic        en,
  input logic        pend,
  input logic        ovf,
  input logic        wrap,
  input logic        rst_req
);
  // R4: a new count is held off for at least one more cycle
  a_r4_busy_min: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    $rose(pend) |=> pend);

  // R6: disabled and idle means the counter does not move
  a_r6_hold: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    (!en && !pend) |=> $stable(cnt));

  // R7: a rollover starts the reset request
  a_r7_req_on_wrap: assert property (@(posedge clk) disable iff (rst_por)
    wrap |=> rst_req);

  // R8: a rollover always leaves the flag set, even against a clearing write
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst_por)
    wrap |=> ovf);

  // R9: the system reset does not touch the flag
  a_r9_flag_kept: assert property (@(posedge clk) disable iff (rst_por)
    (rst_sys && ovf) |=> ovf);
endmodule

bind keyguard_wdt kwdt_checker u_chk (
  .clk    (clk),
  .rst_por(rst_por),
  .rst_sys(rst_sys),
  .cnt    (cnt_q),
  .en     (en_q),
  .pend   (pend_w),
  .ovf    (ovf_q),
  .wrap   (wrap_w),
  .rst_req(wdt_rst_req)
);

// File: tb/keyguard_wdt_tb.sv
module keyguard_wdt_tb;
  localparam logic [31:0] CK = 32'h5A5A_0000;
  localparam logic [31:0] AK = 32'hA5A5_A500;

  logic        clk = 1'b0;
  logic        rst_por = 1'b1;
  logic        rst_sys = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req;

  int checks = 0;
  int errors = 0;
  logic rd_req = 1'b0;
  logic rd_flag = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  keyguard_wdt u_dut (
    .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
  );

  always @(posedge clk) rd_flag <= rd_req;

  // monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if (rd_flag && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read 0x%08h expected 0x%08h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", t, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    bus_addr = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_stopped(input logic [15:0] v);
    wr(4'd4, AK);
    wr(4'd0, CK | 32'(v));
    idle(3);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_por = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(wdt_rst_req, 1'b0, "R1 reset request");
    rd(4'd0, 32'h0, "R1 counter");
    rd(4'd4, 32'h0, "R1 control");
    rd(4'd8, 32'h0, "R1 aux");
    // R10 unmapped
    rd(4'd12, 32'h0, "R10 unmapped");

    // R2 / R4 keyed counter write with busy window
    wr(4'd0, CK | 32'h1234);
    rd(4'd0, 32'h0,  "R4 old count after write edge");
    rd(4'd4, 32'h20, "R4 busy in second cycle");
    rd(4'd0, 32'h1234, "R2 count loaded");
    rd(4'd4, 32'h0,  "R4 busy cleared");
    wr(4'd0, 32'h5A5B_0042); idle(3);
    rd(4'd0, 32'h1234, "R2 bad key ignored");
    wr(4'd0, AK | 32'h42); idle(3);
    rd(4'd0, 32'h1234, "R2 control key ignored at counter");

    // R3 control keys and layout
    wr(4'd8, AK | 32'h3C);
    rd(4'd8, 32'h3C, "R3 aux keyed write");
    wr(4'd8, 32'hA5A5_A4FF);
    rd(4'd8, 32'h3C, "R3 aux bad key ignored");
    wr(4'd4, 32'h1234_5681);
    rd(4'd4, 32'h0, "R3 control bad key ignored");
    wr(4'd4, AK | 32'h6B);
    rd(4'd4, 32'h03, "R3 read-only bits");

    // R5 every divider
    for (int s = 0; s < 8; s++) begin
      int sh;
      case (s)
        0: sh = 0; 1: sh = 2; 2: sh = 4; 3: sh = 5;
        4: sh = 6; 5: sh = 7; 6: sh = 10; default: sh = 12;
      endcase
      load_stopped(16'h0);
      wr(4'd4, AK | 32'h80 | 32'(s));
      idle((2 << sh) - 1);
      rd(4'd0, 32'h1, $sformatf("R5 sel %0d one step", s));
      rd(4'd0, 32'h2, $sformatf("R5 sel %0d two steps", s));
    end

    // R6 stop holds, prescaler cleared
    load_stopped(16'h0);
    wr(4'd4, AK | 32'h82);
    idle(40);
    rd(4'd0, 32'h2, "R6 running sel 2");
    wr(4'd4, AK | 32'h02);
    idle(20);
    rd(4'd0, 32'h2, "R6 held while stopped");
    wr(4'd4, AK | 32'h82);
    idle(15);
    rd(4'd0, 32'h2, "R6 prescaler restarted from zero");
    rd(4'd0, 32'h3, "R6 first step after restart");

    // R7 rollover and pulse length
    load_stopped(16'hFFFF);
    wr(4'd4, AK | 32'h80);
    chk(wdt_rst_req, 1'b0, "R7 request low before rollover");
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 0) chk(wdt_rst_req, 1'b1, "R7 request at rollover");
      if (wdt_rst_req) n++;
    end
    checks++;
    if (n != 16) begin
      errors++;
      $display("FAIL R7 pulse length: %0d expected 16", n);
    end
    rd(4'd4, 32'h90, "R7 flag set");

    // R8 write 1 keeps, write 0 clears
    wr(4'd4, AK | 32'h10);
    rd(4'd4, 32'h10, "R8 write one keeps flag");
    wr(4'd4, AK);
    rd(4'd4, 32'h0, "R8 write zero clears flag");

    // R8 rollover and clear in the same cycle
    load_stopped(16'hFFFF);
    wr(4'd4, AK | 32'h80);
    wr(4'd4, AK | 32'h80);
    rd(4'd4, 32'h90, "R8 rollover beats clear");
    wr(4'd4, AK | 32'h80);
    rd(4'd4, 32'h80, "R8 later clear works");

    // R9 system reset keeps the flag
    load_stopped(16'hFFFF);
    wr(4'd4, AK | 32'h80);
    idle(2);
    rst_sys = 1'b1; idle(2); rst_sys = 1'b0;
    rd(4'd4, 32'h10, "R9 flag survives system reset");
    rd(4'd0, 32'h0,  "R9 counter cleared");
    rd(4'd8, 32'h0,  "R9 aux cleared");
    rst_por = 1'b1; idle(2); rst_por = 1'b0;
    rd(4'd4, 32'h0, "R9 power-on clears flag");
    idle(3);
    finish_run();
  end
endmodule